// File: doc/BRIEF.md
# Pointer-Register Load/Store Address Unit

This block turns a load or store request that names a pointer register into a data-memory access. A sequencer presents the request together with the current value of the chosen pointer, which it reads from an external register file. It also presents a 16-bit constant for absolute accesses. The unit accepts the request in one cycle. In the next cycle it presents the memory address and exactly one read or write strobe. In that same cycle it also presents the new pointer value and a per-pointer write-back enable when the mode changes the pointer.

Four addressing modes are offered. Plain indirect uses the pointer as the address and leaves the pointer alone. Post-increment uses the pointer as the address and writes back the pointer plus one. Pre-decrement subtracts one first and uses that result both as the address and as the write-back value. Absolute mode takes the whole address from the constant. All pointer arithmetic wraps modulo 2^ADDR_W.

Every operation occupies two cycles. The busy output is high in the second cycle, and the sequencer holds its next request off for that cycle. A request made while busy is dropped. A request whose selector names no existing pointer is also dropped.

Top module: `ptr_agu`

## Requirements
- R1: After reset, and in every cycle with no access in progress, acc_busy, mem_rd and mem_wr are 0, and mem_addr, wb_ptr and wb_en are all zero.
- R2: Mode 0 (plain indirect) drives mem_addr equal to req_ptr, and keeps wb_en all zero and wb_ptr zero.
- R3: Mode 1 (post-increment) drives mem_addr equal to req_ptr and wb_ptr equal to req_ptr+1 modulo 2^ADDR_W, so 16'hFFFF writes back 16'h0000.
- R4: Mode 2 (pre-decrement) drives both mem_addr and wb_ptr equal to req_ptr-1 modulo 2^ADDR_W, so 16'h0000 gives 16'hFFFF.
- R5: Mode 3 (absolute) drives mem_addr equal to req_const, and keeps wb_en all zero and wb_ptr zero.
- R6: A request is accepted when req_valid is 1, acc_busy is 0 and req_sel is in range. In the cycle after acceptance, acc_busy is 1 and exactly one strobe is high: mem_wr when req_store is 1, mem_rd when it is 0. In the cycle after that, acc_busy is 0 and both strobes are 0.
- R7: A request presented while acc_busy is 1 is ignored: the following cycle shows the idle outputs of R1.
- R8: wb_en has one bit per pointer, with bit i standing for req_sel value i. In modes 1 and 2 only bit req_sel is set, and only in the busy cycle. A req_sel value of NUM_PTR or more is ignored: no busy, no strobe and no write-back follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 absolute |
| req_sel | input | SEL_W (2) | Pointer register index |
| req_ptr | input | ADDR_W (16) | Current value of the selected pointer |
| req_const | input | ADDR_W (16) | Absolute address for mode 3 |
| acc_busy | output | 1 | Access cycle in progress; the sequencer holds |
| mem_addr | output | ADDR_W (16) | Data-memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| wb_en | output | NUM_PTR (3) | One-hot pointer write-back enable |
| wb_ptr | output | ADDR_W (16) | Updated pointer value |

## Verification
All results of an accepted request appear in the cycle after the accepting clock edge. That cycle is also the only one in which acc_busy is high. The outputs return to idle one edge later. The bench drives each request on a falling edge and checks the access outputs on the next falling edge, which is one register stage later. It then checks for idle outputs on the falling edge after that. For R7, a second request is held on the inputs during the busy cycle, and the idle check then shows that it left no trace.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

   typedef enum logic [1:0] {
      AM_PLAIN   = 2'd0,
      AM_POSTINC = 2'd1,
      AM_PREDEC  = 2'd2,
      AM_ABS     = 2'd3
   } amode_t;

   function automatic logic mode_writes_back(input amode_t m);
      return (m == AM_POSTINC) || (m == AM_PREDEC);
   endfunction

endpackage

// File: rtl/ptr_agu_accept.sv
module ptr_agu_accept #(
   parameter int NUM_PTR = 3,
   parameter int SEL_W   = 2
) (
   input  logic             req_valid,
   input  logic             busy,
   input  logic [SEL_W-1:0] sel,
   output logic             accept
);
   localparam bit FULL_RANGE = ((1 << SEL_W) == NUM_PTR);

   logic in_range;

   generate
      if (FULL_RANGE) begin : g_full
         logic unused_sel;
         assign unused_sel = ^sel;
         assign in_range   = 1'b1;
      end else begin : g_partial
         assign in_range = ({1'b0, sel} < (SEL_W+1)'(NUM_PTR));
      end
   endgenerate

   assign accept = req_valid && !busy && in_range;

endmodule

// File: rtl/ptr_agu_arith.sv
module ptr_agu_arith
   import ptr_agu_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int ADDER_STYLE = 0
) (
   input  amode_t            mode,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] cnst,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] wb_val,
   output logic              wb_need
);
   logic [ADDR_W-1:0] stepped;

   generate
      if (ADDER_STYLE == 0) begin : g_split
         logic [ADDR_W-1:0] inc_v;
         logic [ADDR_W-1:0] dec_v;
         assign inc_v   = ptr + ADDR_W'(1);
         assign dec_v   = ptr - ADDR_W'(1);
         assign stepped = (mode == AM_PREDEC) ? dec_v : inc_v;
      end else begin : g_shared
         logic [ADDR_W-1:0] operand;
         assign operand = (mode == AM_PREDEC) ? {ADDR_W{1'b1}} : ADDR_W'(1);
         assign stepped = ptr + operand;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         AM_PLAIN:   acc_addr = ptr;
         AM_POSTINC: acc_addr = ptr;
         AM_PREDEC:  acc_addr = stepped;
         default:    acc_addr = cnst;
      endcase
   end

   assign wb_need = mode_writes_back(mode);
   assign wb_val  = wb_need ? stepped : '0;

endmodule

// File: rtl/ptr_agu_issue.sv
module ptr_agu_issue #(
   parameter int ADDR_W  = 16,
   parameter int NUM_PTR = 3,
   parameter int SEL_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              is_store,
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [ADDR_W-1:0] wb_val,
   input  logic              wb_need,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [NUM_PTR-1:0] wb_en,
   output logic [ADDR_W-1:0] wb_ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mem_addr <= '0;
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         wb_ptr   <= '0;
      end else if (accept) begin
         busy     <= 1'b1;
         mem_addr <= acc_addr;
         mem_rd   <= !is_store;
         mem_wr   <= is_store;
         wb_ptr   <= wb_val;
      end else begin
         busy     <= 1'b0;
         mem_addr <= '0;
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         wb_ptr   <= '0;
      end
   end

   generate
      for (genvar i = 0; i < NUM_PTR; i++) begin : g_wb
         always_ff @(posedge clk) begin
            if (!rst_n) wb_en[i] <= 1'b0;
            else        wb_en[i] <= accept && wb_need && (sel == SEL_W'(i));
         end
      end
   endgenerate

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import ptr_agu_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int NUM_PTR     = 3,
   parameter int ADDER_STYLE = 0,
   localparam int SEL_W      = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_store,
   input  logic [1:0]         req_mode,
   input  logic [SEL_W-1:0]   req_sel,
   input  logic [ADDR_W-1:0]  req_ptr,
   input  logic [ADDR_W-1:0]  req_const,
   output logic               acc_busy,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [NUM_PTR-1:0] wb_en,
   output logic [ADDR_W-1:0]  wb_ptr
);
   initial begin
      assert (ADDR_W >= 2) else $error("ptr_agu: ADDR_W must be at least 2");
      assert (NUM_PTR >= 2) else $error("ptr_agu: NUM_PTR must be at least 2");
      assert (ADDER_STYLE == 0 || ADDER_STYLE == 1)
         else $error("ptr_agu: ADDER_STYLE must be 0 or 1");
   end

   logic              accept;
   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] wb_val;
   logic              wb_need;
   amode_t            mode;

   assign mode = amode_t'(req_mode);

   ptr_agu_accept #(.NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_accept (
      .req_valid (req_valid),
      .busy      (acc_busy),
      .sel       (req_sel),
      .accept    (accept)
   );

   ptr_agu_arith #(.ADDR_W(ADDR_W), .ADDER_STYLE(ADDER_STYLE)) u_arith (
      .mode     (mode),
      .ptr      (req_ptr),
      .cnst     (req_const),
      .acc_addr (acc_addr),
      .wb_val   (wb_val),
      .wb_need  (wb_need)
   );

   ptr_agu_issue #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .is_store (req_store),
      .sel      (req_sel),
      .acc_addr (acc_addr),
      .wb_val   (wb_val),
      .wb_need  (wb_need),
      .busy     (acc_busy),
      .mem_addr (mem_addr),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .wb_en    (wb_en),
      .wb_ptr   (wb_ptr)
   );

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
   parameter int ADDR_W  = 16,
   parameter int NUM_PTR = 3,
   parameter int SEL_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_store,
   input logic [1:0]         req_mode,
   input logic [SEL_W-1:0]   req_sel,
   input logic [ADDR_W-1:0]  req_ptr,
   input logic [ADDR_W-1:0]  req_const,
   input logic               acc_busy,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_rd,
   input logic               mem_wr,
   input logic [NUM_PTR-1:0] wb_en,
   input logic [ADDR_W-1:0]  wb_ptr
);
   logic taken;
   assign taken = req_valid && !acc_busy && ({1'b0, req_sel} < (SEL_W+1)'(NUM_PTR));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_busy |-> (!mem_rd && !mem_wr && wb_en == '0 && wb_ptr == '0 && mem_addr == '0));

   p_plain_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && req_mode == 2'd0) |=> (mem_addr == $past(req_ptr) && wb_en == '0));

   p_post_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && req_mode == 2'd1) |=> (mem_addr == $past(req_ptr)
                                       && wb_ptr == ADDR_W'(mem_addr + 1'b1)));

   p_pre_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && req_mode == 2'd2) |=> (mem_addr == ADDR_W'($past(req_ptr) - 1'b1)
                                       && wb_ptr == mem_addr));

   p_abs_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && req_mode == 2'd3) |=> (mem_addr == $past(req_const) && wb_en == '0));

   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_busy |-> (mem_rd != mem_wr));

   p_store_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> (acc_busy && mem_wr == $past(req_store)));

   p_single_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_busy |=> !acc_busy);

   p_wb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wb_en));

   p_wb_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en != '0) |-> acc_busy);

endmodule

bind ptr_agu ptr_agu_chk #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/ptr_agu_tb_top.sv
module ptr_agu_tb_top;
   localparam int CLK_P  = 10;
   localparam int AW     = 16;
   localparam int NP     = 3;
   localparam int SW     = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_store = 1'b0;
   logic [1:0]    req_mode = 2'd0;
   logic [SW-1:0] req_sel = '0;
   logic [AW-1:0] req_ptr = '0;
   logic [AW-1:0] req_const = '0;
   logic          acc_busy;
   logic [AW-1:0] mem_addr;
   logic          mem_rd;
   logic          mem_wr;
   logic [NP-1:0] wb_en;
   logic [AW-1:0] wb_ptr;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ptr_agu #(.ADDR_W(AW), .NUM_PTR(NP), .ADDER_STYLE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_mode(req_mode), .req_sel(req_sel), .req_ptr(req_ptr), .req_const(req_const),
      .acc_busy(acc_busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .wb_en(wb_en), .wb_ptr(wb_ptr)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(tag, "busy", {31'd0, acc_busy}, 32'd0);
      chk(tag, "rd", {31'd0, mem_rd}, 32'd0);
      chk(tag, "wr", {31'd0, mem_wr}, 32'd0);
      chk(tag, "addr", {16'd0, mem_addr}, 32'd0);
      chk(tag, "wb_en", {29'd0, wb_en}, 32'd0);
      chk(tag, "wb_ptr", {16'd0, wb_ptr}, 32'd0);
   endtask

   function automatic logic [AW-1:0] pattern(input int k);
      case (k)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h7FFF;
         3: return 16'h8000;
         4: return 16'hFFFE;
         default: return 16'hFFFF;
      endcase
   endfunction

   task automatic run_op(input int mode, input bit st, input int sel,
                         input logic [AW-1:0] p, input bit hold);
      logic [AW-1:0] cst;
      logic [AW-1:0] e_addr;
      logic [AW-1:0] e_wb;
      logic [NP-1:0] e_en;
      bit            ok;
      string         tag;
      cst = ~p ^ 16'h5A5A;
      ok  = (sel < NP);
      case (mode)
         0: begin e_addr = p;            e_wb = '0;           tag = "R2"; end
         1: begin e_addr = p;            e_wb = AW'(p + 1);   tag = "R3"; end
         2: begin e_addr = AW'(p - 1);   e_wb = AW'(p - 1);   tag = "R4"; end
         default: begin e_addr = cst;    e_wb = '0;           tag = "R5"; end
      endcase
      e_en = (mode == 1 || mode == 2) ? NP'(1 << sel) : '0;
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_mode = 2'(mode);
      req_sel = SW'(sel); req_ptr = p; req_const = cst;
      @(negedge clk);
      if (hold) begin
         req_valid = 1'b1; req_mode = 2'd1; req_sel = '0;
         req_ptr = 16'h1234; req_store = 1'b1;
      end else begin
         req_valid = 1'b0;
      end
      if (ok) begin
         chk(tag, "addr", {16'd0, mem_addr}, {16'd0, e_addr});
         chk(tag, "wb_ptr", {16'd0, wb_ptr}, {16'd0, e_wb});
         chk("R8", "wb_en", {29'd0, wb_en}, {29'd0, e_en});
         chk("R6", "busy", {31'd0, acc_busy}, 32'd1);
         chk("R6", "rd", {31'd0, mem_rd}, {31'd0, !st});
         chk("R6", "wr", {31'd0, mem_wr}, {31'd0, st});
      end else begin
         chk_idle("R8");
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (ok) chk_idle(hold ? "R7" : "R6");
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int sl = 0; sl < 4; sl++)
               for (int k = 0; k < 6; k++)
                  run_op(m, s[0], sl, pattern(k), ((k + sl) % 2) == 1);
      for (int sl = 0; sl < NP; sl++)
         for (int v = 0; v < 16; v++) begin
            run_op(1, 1'b0, sl, AW'(v * 16'h1111 + sl), 1'b0);
            run_op(2, 1'b1, sl, AW'(v * 16'h0F0F + sl), 1'b1);
         end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule